// File: doc/BRIEF.md
# Word Load Execution Unit

This unit executes the four zero-extending 32-bit word loads of a 64-bit big-endian RISC core. Those four loads are the displacement form, the displacement form with base update, the register-indexed form, and the indexed form with base update. The unit takes one 32-bit instruction word on a valid/ready handshake and decodes it. It then reads the base register and the index register through two combinational register-file read ports. From these it forms a 32-bit effective address and registers it.

The unit then issues a single word read on a valid/ready memory request channel. When the read data comes back, it writes the loaded word, zero-extended, into the destination register. Update forms also write the effective address back into the base register through a second write port in the same cycle. Encodings that are not one of the four loads, and update encodings that are malformed, are reported on a one-cycle flag. The unit does nothing else for them.

The register file, caches and memory ordering sit outside the unit. So do all other load widths and the sign-extending loads.

Top module: `wload_unit`

## Requirements
- R1: The primary opcode sits in ins_word[31:26] (instruction bit 0 is the MSB). Opcode 32 is the displacement load, 33 the displacement load with update, and 31 an indexed load. For opcode 31, the field ins_word[10:1] selects the plain indexed form with 23 and the indexed update form with 55. The destination field is ins_word[25:21], the base field ins_word[20:16] and the index field ins_word[15:11].
- R2: Displacement forms add the 16-bit field ins_word[15:0], sign-extended to 64 bits, to the base. Indexed forms add the full 64-bit value read for the index field.
- R3: In the displacement and indexed forms without update, a base field of 0 gives a literal zero base instead of register 0. The update forms always use the register value.
- R4: The address on mem_req_addr is the low 32 bits of the 64-bit sum. Any carry beyond bit 31 is dropped.
- R5: The destination write carries the loaded word in bits 31:0 and zeros in bits 63:32.
- R6: Update forms also write the effective address, zero-extended to 64 bits, to the base register through the second write port. Forms without update never enable that port.
- R7: Memory is big-endian. mem_rsp_data[7:0] holds the byte at the effective address, [15:8] the byte at address+1, [23:16] the byte at address+2 and [31:24] the byte at address+3. The loaded word is byte@EA in bits 31:24 down to byte@EA+3 in bits 7:0.
- R8: A load whose address is not a multiple of 4 is issued with that exact address and completes normally.
- R9: A word that is not one of the four loads is invalid. So is an update form whose base field is 0 or equals the destination field. For an invalid word, bad_form is high for exactly one cycle, and there is no memory request and no register write.
- R10: ins_ready is high only while idle. Once raised, a memory request keeps its address unchanged until mem_req_ready is seen.
- R11: Write enables are high in exactly the cycle mem_rsp_valid is accepted, and done is high for the one following cycle.
- R12: Synchronous active-high reset returns the unit to idle with the request, write enables, bad_form and done low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ins_valid | input | 1 | Instruction word offered |
| ins_ready | output | 1 | Unit idle and accepting |
| ins_word | input | 32 | Instruction word |
| rf_a_idx | output | 5 | Base register read index |
| rf_a_data | input | 64 | Base register value |
| rf_b_idx | output | 5 | Index register read index |
| rf_b_data | input | 64 | Index register value |
| mem_req_valid | output | 1 | Word read requested |
| mem_req_ready | input | 1 | Memory accepts request |
| mem_req_addr | output | 32 | Effective byte address |
| mem_rsp_valid | input | 1 | Read data returned |
| mem_rsp_data | input | 32 | Returned bytes, lane 0 = byte at address |
| wb_d_en | output | 1 | Destination write enable |
| wb_d_idx | output | 5 | Destination register |
| wb_d_data | output | 64 | Destination value |
| wb_u_en | output | 1 | Base-update write enable |
| wb_u_idx | output | 5 | Base register to update |
| wb_u_data | output | 64 | Updated base value |
| bad_form | output | 1 | Invalid-form pulse |
| done | output | 1 | Load completed pulse |

## Verification
The destination write and the base-update write land in the same cycle on separate ports. The bench runs every update-form load over all 32 base fields and places the destination in a different register each time. In the cycle the response is driven, it checks both enables, both indices and both data values against arithmetic it computes itself. In that same sweep, base field 0 must give a zero base for the forms without update but the invalid flag for the update forms, and the bench judges each case by whether a request or any write appears.

// File: rtl/wload_pkg.sv
package wload_pkg;
  localparam int unsigned INSN_W  = 32;
  localparam int unsigned RIDX_W  = 5;
  localparam int unsigned DISP_W  = 16;
  localparam logic [5:0] OPC_DISP  = 6'd32;
  localparam logic [5:0] OPC_DISPU = 6'd33;
  localparam logic [5:0] OPC_EXT   = 6'd31;
  localparam logic [9:0] XOP_IDX   = 10'd23;
  localparam logic [9:0] XOP_IDXU  = 10'd55;

  typedef enum logic [1:0] {ST_IDLE, ST_DEC, ST_REQ, ST_RESP} ld_state_e;

  typedef struct packed {
    logic [RIDX_W-1:0] rt;
    logic [RIDX_W-1:0] ra;
    logic [RIDX_W-1:0] rb;
    logic [DISP_W-1:0] disp;
    logic              upd;
    logic              disp_form;
    logic              zero_base;
    logic              bad;
  } ld_dec_t;
endpackage

// File: rtl/wload_decode.sv
module wload_decode
  import wload_pkg::*;
(
  input  logic [INSN_W-1:0] word,
  output ld_dec_t           dec
);
  logic [5:0] opcd;
  logic [9:0] xop;
  logic is_disp, is_dispu, is_idx, is_idxu, known, upd;

  assign opcd     = word[31:26];
  assign xop      = word[10:1];
  assign is_disp  = (opcd == OPC_DISP);
  assign is_dispu = (opcd == OPC_DISPU);
  assign is_idx   = (opcd == OPC_EXT) && (xop == XOP_IDX);
  assign is_idxu  = (opcd == OPC_EXT) && (xop == XOP_IDXU);
  assign known    = is_disp | is_dispu | is_idx | is_idxu;
  assign upd      = is_dispu | is_idxu;

  always_comb begin
    dec.rt        = word[25:21];
    dec.ra        = word[20:16];
    dec.rb        = word[15:11];
    dec.disp      = word[15:0];
    dec.upd       = upd;
    dec.disp_form = is_disp | is_dispu;
    dec.zero_base = (is_disp | is_idx) && (word[20:16] == '0);
    dec.bad       = !known || (upd && ((word[20:16] == '0) ||
                                       (word[20:16] == word[25:21])));
  end
endmodule

// File: rtl/wload_agu.sv
module wload_agu #(
  parameter int unsigned XLEN   = 64,
  parameter int unsigned AW     = 32,
  parameter int unsigned DISP_W = 16
) (
  input  logic              zero_base,
  input  logic              disp_form,
  input  logic [DISP_W-1:0] disp,
  input  logic [XLEN-1:0]   base_val,
  input  logic [XLEN-1:0]   idx_val,
  output logic [AW-1:0]     ea
);
  logic [XLEN-1:0] base, offs, sum;

  assign base = zero_base ? '0 : base_val;
  assign offs = disp_form ? {{(XLEN-DISP_W){disp[DISP_W-1]}}, disp} : idx_val;
  assign sum  = base + offs;
  assign ea   = sum[AW-1:0];
endmodule

// File: rtl/wload_bswap.sv
module wload_bswap #(
  parameter int unsigned DW = 32
) (
  input  logic [DW-1:0] lanes,
  output logic [DW-1:0] word
);
  localparam int unsigned NB = DW / 8;

  for (genvar i = 0; i < NB; i++) begin : g_lane
    assign word[(NB-1-i)*8 +: 8] = lanes[i*8 +: 8];
  end
endmodule

// File: rtl/wload_ctrl.sv
module wload_ctrl
  import wload_pkg::*;
#(
  parameter int unsigned XLEN = 64,
  parameter int unsigned AW   = 32,
  parameter int unsigned LD_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              ins_valid,
  input  logic [INSN_W-1:0] ins_word,
  output logic              ins_ready,
  output logic [INSN_W-1:0] insn_q,
  input  ld_dec_t           dec,
  input  logic [AW-1:0]     ea_next,
  output logic              mem_req_valid,
  input  logic              mem_req_ready,
  output logic [AW-1:0]     mem_req_addr,
  input  logic              mem_rsp_valid,
  input  logic [LD_W-1:0]   load_word,
  output logic              wb_d_en,
  output logic [RIDX_W-1:0] wb_d_idx,
  output logic [XLEN-1:0]   wb_d_data,
  output logic              wb_u_en,
  output logic [RIDX_W-1:0] wb_u_idx,
  output logic [XLEN-1:0]   wb_u_data,
  output logic              bad_form,
  output logic              done
);
  ld_state_e         state;
  logic [AW-1:0]     ea_q;
  logic [RIDX_W-1:0] rt_q, ra_q;
  logic              upd_q, bad_q, done_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      state  <= ST_IDLE;
      insn_q <= '0;
      ea_q   <= '0;
      rt_q   <= '0;
      ra_q   <= '0;
      upd_q  <= 1'b0;
      bad_q  <= 1'b0;
      done_q <= 1'b0;
    end else begin
      bad_q  <= 1'b0;
      done_q <= 1'b0;
      case (state)
        ST_IDLE: if (ins_valid) begin
          insn_q <= ins_word;
          state  <= ST_DEC;
        end
        ST_DEC: if (dec.bad) begin
          bad_q <= 1'b1;
          state <= ST_IDLE;
        end else begin
          ea_q  <= ea_next;
          rt_q  <= dec.rt;
          ra_q  <= dec.ra;
          upd_q <= dec.upd;
          state <= ST_REQ;
        end
        ST_REQ:  if (mem_req_ready) state <= ST_RESP;
        ST_RESP: if (mem_rsp_valid) begin
          done_q <= 1'b1;
          state  <= ST_IDLE;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  assign ins_ready     = (state == ST_IDLE);
  assign mem_req_valid = (state == ST_REQ);
  assign mem_req_addr  = ea_q;
  assign wb_d_en       = (state == ST_RESP) && mem_rsp_valid;
  assign wb_d_idx      = rt_q;
  assign wb_d_data     = {{(XLEN-LD_W){1'b0}}, load_word};
  assign wb_u_en       = wb_d_en && upd_q;
  assign wb_u_idx      = ra_q;
  assign wb_u_data     = {{(XLEN-AW){1'b0}}, ea_q};
  assign bad_form      = bad_q;
  assign done          = done_q;

  // R10
  req_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (mem_req_valid && !mem_req_ready) |=> (mem_req_valid && $stable(mem_req_addr)));

  // R9
  bad_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    bad_form |-> (!mem_req_valid && !wb_d_en && !wb_u_en));

  // R11
  done_after_wb_chk: assert property (@(posedge clk) disable iff (rst)
    done |-> $past(wb_d_en));

  // R6
  upd_pair_chk: assert property (@(posedge clk) disable iff (rst)
    wb_u_en |-> (wb_d_en && (wb_u_idx != wb_d_idx) && (wb_u_idx != '0)));
endmodule

// File: rtl/wload_unit.sv
module wload_unit
  import wload_pkg::*;
#(
  parameter int unsigned XLEN = 64,
  parameter int unsigned AW   = 32,
  parameter int unsigned LD_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              ins_valid,
  output logic              ins_ready,
  input  logic [31:0]       ins_word,
  output logic [4:0]        rf_a_idx,
  input  logic [XLEN-1:0]   rf_a_data,
  output logic [4:0]        rf_b_idx,
  input  logic [XLEN-1:0]   rf_b_data,
  output logic              mem_req_valid,
  input  logic              mem_req_ready,
  output logic [AW-1:0]     mem_req_addr,
  input  logic              mem_rsp_valid,
  input  logic [LD_W-1:0]   mem_rsp_data,
  output logic              wb_d_en,
  output logic [4:0]        wb_d_idx,
  output logic [XLEN-1:0]   wb_d_data,
  output logic              wb_u_en,
  output logic [4:0]        wb_u_idx,
  output logic [XLEN-1:0]   wb_u_data,
  output logic              bad_form,
  output logic              done
);
  logic [INSN_W-1:0] insn_q;
  ld_dec_t           dec;
  logic [AW-1:0]     ea_next;
  logic [LD_W-1:0]   load_word;

  wload_decode u_dec (.word(insn_q), .dec(dec));

  assign rf_a_idx = dec.ra;
  assign rf_b_idx = dec.rb;

  wload_agu #(.XLEN(XLEN), .AW(AW), .DISP_W(DISP_W)) u_agu (
    .zero_base(dec.zero_base), .disp_form(dec.disp_form), .disp(dec.disp),
    .base_val(rf_a_data), .idx_val(rf_b_data), .ea(ea_next));

  wload_bswap #(.DW(LD_W)) u_swap (.lanes(mem_rsp_data), .word(load_word));

  wload_ctrl #(.XLEN(XLEN), .AW(AW), .LD_W(LD_W)) u_ctrl (
    .clk(clk), .rst(rst), .ins_valid(ins_valid), .ins_word(ins_word),
    .ins_ready(ins_ready), .insn_q(insn_q), .dec(dec), .ea_next(ea_next),
    .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready),
    .mem_req_addr(mem_req_addr), .mem_rsp_valid(mem_rsp_valid),
    .load_word(load_word), .wb_d_en(wb_d_en), .wb_d_idx(wb_d_idx),
    .wb_d_data(wb_d_data), .wb_u_en(wb_u_en), .wb_u_idx(wb_u_idx),
    .wb_u_data(wb_u_data), .bad_form(bad_form), .done(done));

  // R5
  zext_chk: assert property (@(posedge clk) disable iff (rst)
    wb_d_en |-> (wb_d_data[XLEN-1:LD_W] == '0 && wb_d_data[LD_W-1:0] == load_word));

  // R11
  wb_with_rsp_chk: assert property (@(posedge clk) disable iff (rst)
    wb_d_en |-> (mem_rsp_valid && !mem_req_valid && !ins_ready));
endmodule

// File: tb/sim_wload_unit.sv
`timescale 1ns/100ps
module sim_wload_unit;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        ins_valid = 1'b0;
  logic        ins_ready;
  logic [31:0] ins_word = '0;
  logic [4:0]  rf_a_idx, rf_b_idx;
  logic [63:0] rf_a_data, rf_b_data;
  logic        mem_req_valid;
  logic        mem_req_ready = 1'b0;
  logic [31:0] mem_req_addr;
  logic        mem_rsp_valid = 1'b0;
  logic [31:0] mem_rsp_data = '0;
  logic        wb_d_en, wb_u_en, bad_form, done;
  logic [4:0]  wb_d_idx, wb_u_idx;
  logic [63:0] wb_d_data, wb_u_data;

  int checks = 0;
  int fails  = 0;
  int wb_cnt = 0;
  int req_cnt = 0;

  always #2.5 clk = ~clk;

  wload_unit u0 (.*);

  function automatic logic [63:0] rv(input int i);
    logic [31:0] lo;
    lo = 32'h8000_0000 + 32'(i) * 32'h0AB1_2347;
    return {16'hC0DE, 11'd0, 5'(i), lo};
  endfunction

  assign rf_a_data = rv(int'(rf_a_idx));
  assign rf_b_data = rv(int'(rf_b_idx));

  function automatic logic [7:0] mb(input logic [31:0] a);
    return (a[7:0] * 8'd7) ^ a[23:16] ^ 8'hA5;
  endfunction

  always @(posedge clk) begin
    if (wb_d_en || wb_u_en) wb_cnt <= wb_cnt + 1;
    if (mem_req_valid && mem_req_ready) req_cnt <= req_cnt + 1;
  end

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] enc(input int form, input int rt, input int ra, input int rb, input logic [15:0] d);
    case (form)
      0: return {6'd32, 5'(rt), 5'(ra), d};
      1: return {6'd33, 5'(rt), 5'(ra), d};
      2: return {6'd31, 5'(rt), 5'(ra), 5'(rb), 10'd23, 1'b0};
      default: return {6'd31, 5'(rt), 5'(ra), 5'(rb), 10'd55, 1'b0};
    endcase
  endfunction

  task automatic run(input logic [31:0] w, input bit exp_bad, input int form,
                     input int rt, input int ra, input int rb, input logic [15:0] d,
                     input int stall, input int lat);
    logic [63:0] base, offs, sum;
    logic [31:0] ea, expw;
    bit upd;
    int wb0, rq0;
    upd  = (form == 1) || (form == 3);
    base = (ra == 0 && !upd) ? 64'd0 : rv(ra);
    offs = (form < 2) ? {{48{d[15]}}, d} : rv(rb);
    sum  = base + offs;
    ea   = sum[31:0];
    expw = {mb(ea), mb(ea + 1), mb(ea + 2), mb(ea + 3)};
    wb0 = wb_cnt; rq0 = req_cnt;
    @(negedge clk);
    chk(ins_ready == 1'b1, "R10 ready idle", 64'(ins_ready), 64'd1);
    ins_valid = 1'b1; ins_word = w;
    @(negedge clk);
    ins_valid = 1'b0;
    chk(ins_ready == 1'b0, "R10 ready busy", 64'(ins_ready), 64'd0);
    @(negedge clk);
    if (exp_bad) begin
      chk(bad_form == 1'b1, "R9 flag", 64'(bad_form), 64'd1);
      chk(mem_req_valid == 1'b0, "R9 no request", 64'(mem_req_valid), 64'd0);
      @(negedge clk);
      chk(bad_form == 1'b0, "R9 one cycle", 64'(bad_form), 64'd0);
      chk(wb_cnt == wb0 && req_cnt == rq0, "R9 no activity",
          64'(wb_cnt - wb0 + req_cnt - rq0), 64'd0);
      return;
    end
    chk(mem_req_valid == 1'b1, "R1 request", 64'(mem_req_valid), 64'd1);
    chk(mem_req_addr == ea, "R2 address", 64'(mem_req_addr), 64'(ea));
    if (ra == 0) chk(mem_req_addr == ea, "R3 zero base", 64'(mem_req_addr), 64'(ea));
    if (sum[63:32] != 32'd0)
      chk(mem_req_addr == ea, "R4 truncation", 64'(mem_req_addr), 64'(ea));
    for (int s = 0; s < stall; s++) begin
      @(negedge clk);
      chk(mem_req_valid && mem_req_addr == ea, "R10 hold", 64'(mem_req_addr), 64'(ea));
    end
    mem_req_ready = 1'b1;
    @(negedge clk);
    mem_req_ready = 1'b0;
    chk(mem_req_valid == 1'b0, "R10 request dropped", 64'(mem_req_valid), 64'd0);
    for (int l = 0; l < lat; l++) begin
      chk(wb_d_en == 1'b0, "R11 no early write", 64'(wb_d_en), 64'd0);
      @(negedge clk);
    end
    mem_rsp_data  = {mb(ea + 3), mb(ea + 2), mb(ea + 1), mb(ea)};
    mem_rsp_valid = 1'b1;
    #1;
    chk(wb_d_en == 1'b1, "R11 write enable", 64'(wb_d_en), 64'd1);
    chk(wb_d_idx == 5'(rt), "R1 destination", 64'(wb_d_idx), 64'(rt));
    chk(wb_d_data == {32'd0, expw}, "R5 R7 loaded word", wb_d_data, {32'd0, expw});
    chk(wb_u_en == upd, "R6 update enable", 64'(wb_u_en), 64'(upd));
    if (upd) begin
      chk(wb_u_idx == 5'(ra), "R6 update index", 64'(wb_u_idx), 64'(ra));
      chk(wb_u_data == {32'd0, ea}, "R6 update value", wb_u_data, {32'd0, ea});
    end
    @(negedge clk);
    mem_rsp_valid = 1'b0;
    chk(done == 1'b1 && wb_d_en == 1'b0, "R11 done", 64'(done), 64'd1);
    if (ea[1:0] != 2'b00) chk(done == 1'b1, "R8 unaligned completes", 64'(done), 64'd1);
    @(negedge clk);
    chk(done == 1'b0, "R11 done one cycle", 64'(done), 64'd0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL R11 watchdog actual=hung expected=finished");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk(!mem_req_valid && !wb_d_en && !wb_u_en && !bad_form && !done, "R12 reset outputs",
        {mem_req_valid, wb_d_en, wb_u_en, bad_form, done}, 64'd0);
    rst = 1'b0;
    @(negedge clk);
    chk(ins_ready == 1'b1, "R12 idle after reset", 64'(ins_ready), 64'd1);

    for (int form = 0; form < 4; form++) begin
      for (int ra = 0; ra < 32; ra++) begin
        int rt, rb;
        logic [15:0] d;
        bit bad;
        rt = (ra + 5) % 32;
        rb = (ra * 7 + 3) % 32;
        d  = (ra % 2 == 0) ? 16'(ra * 97 + 1) : 16'h8000 + 16'(ra * 13);
        bad = (form == 1 || form == 3) && (ra == 0);
        run(enc(form, rt, ra, rb, d), bad, form, rt, ra, rb, d, ra % 3, (ra + form) % 3);
      end
    end

    // R9: update forms naming the destination as base
    run(enc(1, 7, 7, 0, 16'd4), 1'b1, 1, 7, 7, 0, 16'd4, 0, 0);
    run(enc(3, 9, 9, 2, 16'd0), 1'b1, 3, 9, 9, 2, 16'd0, 0, 0);
    // R1: unknown opcodes and extended codes
    run({6'd34, 5'd1, 5'd2, 16'd8}, 1'b1, 0, 1, 2, 0, 16'd8, 0, 0);
    run({6'd31, 5'd1, 5'd2, 5'd3, 10'd87, 1'b0}, 1'b1, 2, 1, 2, 3, 16'd0, 0, 0);
    run({6'd31, 5'd1, 5'd2, 5'd3, 10'd24, 1'b0}, 1'b1, 2, 1, 2, 3, 16'd0, 0, 0);

    // R12: reset in the middle of a request
    @(negedge clk);
    ins_valid = 1'b1; ins_word = enc(0, 3, 4, 0, 16'd8);
    @(negedge clk); ins_valid = 1'b0;
    @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    chk(!mem_req_valid && ins_ready, "R12 reset mid load", 64'(mem_req_valid), 64'd0);
    rst = 1'b0;
    run(enc(2, 11, 12, 13, 16'd0), 1'b0, 2, 11, 12, 13, 16'd0, 1, 2);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule